// File: doc/BRIEF.md
# Event Timer with Prescaled Counting, Compare and Input Capture

This block is a 16-bit up-counter for interrupt-driven timing. A clock divider feeds it one count tick every 1, 8, 64, 256 or 1024 system clocks, or no ticks at all when it is stopped. Three events come out of the counting: a wrap from the all-ones value back to zero, a match between the count and a programmable compare value, and a capture, where an edge on an external pin copies the live count into a capture register.

Each event sets a sticky flag. Software clears a flag by writing a one to its bit. Each flag has its own enable, and a single interrupt line is raised while any enabled flag is set. Software reaches everything through a simple register port: a synchronous write and a combinational read, each with a 3-bit address. There is no streaming data path, so all pins are plain control and status signals with no valid/ready handshake and no back-pressure.

Top module: `evt_timer`

## Requirements
- R1: After reset, count, compare, capture, control, enables and flags all read zero, and `irq` is low.
- R2: The address map is as follows.
  - Address 0 is the count, 1 the compare value and 2 the capture value. The capture value is read-only, so a write to address 2 is ignored.
  - Address 3 is control: bits [2:0] hold the prescale code and bit 3 the edge select.
  - Address 4 holds the enables in bits [2:0], and address 5 the flags in bits [2:0].
  - In the enables and the flags, bit 0 is overflow, bit 1 is compare and bit 2 is capture.
  - Addresses 6 and 7 read zero.
- R3: Prescale code 0 stops the count, and so do the unused codes 6 and 7. While stopped, the count changes only by a register write.
- R4: Codes 1 to 5 select divide ratios 1, 8, 64, 256 and 1024. Any write to control restarts the divider, so M clock edges after that write the count has advanced by floor(M / ratio).
- R5: A tick that arrives while the count is 0xFFFF wraps it to 0 and sets the overflow flag on that same edge.
- R6: A tick that arrives while the count equals the compare value sets the compare flag on that same edge.
- R7: A count write takes effect on its own edge, ahead of any tick. It also cancels a compare match in that cycle.
- R8: Capture works in three stages.
  - The capture pin passes through two synchronising flops before edge detection.
  - Edge select 1 captures on a rising edge and 0 on a falling edge. The other edge does nothing.
  - On a selected edge the count is copied into the capture register and the capture flag is set, at most four edges after the pin changes.
- R9: Writing a 1 to a flag bit clears that flag. If an event sets the same flag in the same cycle, the set wins.
- R10: A flag is set by its event whether or not it is enabled. `irq` is high exactly while some flag is set together with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default 16-bit count and 10-bit divider. It preloads the count close to 0xFFFF so the wrap is reached in a couple of ticks, and it places the count just below the compare value so a match happens a known number of cycles after the counter starts. The largest ratio, 1024, needs about two thousand cycles to produce two ticks, which keeps every divide ratio within reach. Same-cycle collisions are lined up edge by edge: a clear meeting a wrap, and a count write meeting a match.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int PS_LOG2_MAX = 10;
  localparam int EVT_N   = 3;
  localparam int EVT_OVF = 0;
  localparam int EVT_CMP = 1;
  localparam int EVT_CAP = 2;

  localparam logic [2:0] A_CNT = 3'd0;
  localparam logic [2:0] A_CMP = 3'd1;
  localparam logic [2:0] A_CAP = 3'd2;
  localparam logic [2:0] A_CTL = 3'd3;
  localparam logic [2:0] A_ENA = 3'd4;
  localparam logic [2:0] A_FLG = 3'd5;

  function automatic logic ps_running(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

  function automatic int unsigned ps_shift(input logic [2:0] code);
    case (code)
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return PS_LOG2_MAX;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/evtmr_prescaler.sv
module evtmr_prescaler
  import evtmr_pkg::*;
#(
  parameter int PS_W = PS_LOG2_MAX
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PS_W-1:0] presc_q;
  logic [PS_W-1:0] mask;
  logic            running;

  always_comb begin
    running = ps_running(code);
    mask    = (PS_W'(1) << ps_shift(code)) - PS_W'(1);
    tick    = running && ((presc_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !running) presc_q <= '0;
    else                               presc_q <= presc_q + PS_W'(1);
  end

  // R3: a stopped divider stays parked at zero
  p_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (presc_q == '0));
endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             cmp_evt
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    ovf_evt = tick && !ld && (cnt_q == '1);
    cmp_evt = tick && !ld && (cnt_q == cmp_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (tick) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt = cnt_q;

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == '0));
  p_load_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val)));
endmodule

// File: rtl/evtmr_capture.sv
module evtmr_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             rise_sel,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt
);
  logic sync1_q, sync2_q, prev_q;
  logic [CNT_W-1:0] cap_q;

  always_comb begin
    cap_evt = rise_sel ? (sync2_q && !prev_q) : (!sync2_q && prev_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      cap_q   <= '0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (cap_evt) cap_q <= cnt;
    end
  end

  assign cap_val = cap_q;

  p_copy_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt)));
  p_hold_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));
endmodule

// File: rtl/evtmr_flags.sv
module evtmr_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= (flg_q & ~clr) | set;
  end

  assign flags = flg_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flg_q & $past(set)) == $past(set)));
  p_clear_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((flg_q & $past(clr & ~set)) == '0));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evtmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = PS_LOG2_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             cap_pin,
  output logic             irq
);
  logic [CNT_W-1:0] cmp_q, cnt, cap_val;
  logic [2:0]       code_q;
  logic             rise_q;
  logic [EVT_N-1:0] en_q, flags, set_vec, clr_vec;
  logic             tick, ovf_evt, cmp_evt, cap_evt;
  logic             wr_cnt, wr_ctl;

  always_comb begin
    wr_cnt  = wr_en && (wr_addr == A_CNT);
    wr_ctl  = wr_en && (wr_addr == A_CTL);
    clr_vec = (wr_en && (wr_addr == A_FLG)) ? wr_data[EVT_N-1:0] : '0;
    set_vec = '0;
    set_vec[EVT_OVF] = ovf_evt;
    set_vec[EVT_CMP] = cmp_evt;
    set_vec[EVT_CAP] = cap_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      code_q <= '0;
      rise_q <= 1'b0;
      en_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CMP: cmp_q <= wr_data;
        A_CTL: begin
          code_q <= wr_data[2:0];
          rise_q <= wr_data[3];
        end
        A_ENA: en_q <= wr_data[EVT_N-1:0];
        default: ;
      endcase
    end
  end

  evtmr_prescaler #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(wr_ctl), .code(code_q), .tick(tick)
  );

  evtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(wr_cnt), .ld_val(wr_data),
    .cmp_val(cmp_q), .cnt(cnt), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );

  evtmr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise_sel(rise_q), .cnt(cnt),
    .cap_val(cap_val), .cap_evt(cap_evt)
  );

  evtmr_flags #(.N(EVT_N)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec), .flags(flags)
  );

  always_comb begin
    case (rd_addr)
      A_CNT:   rd_data = cnt;
      A_CMP:   rd_data = cmp_q;
      A_CAP:   rd_data = cap_val;
      A_CTL:   rd_data = CNT_W'({rise_q, code_q});
      A_ENA:   rd_data = CNT_W'(en_q);
      A_FLG:   rd_data = CNT_W'(flags);
      default: rd_data = '0;
    endcase
    irq = |(flags & en_q);
  end

  p_stop_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ps_running(code_q) && !wr_cnt) |=> $stable(cnt));
  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && en_q == '0));
endmodule

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cap_pin = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_pin(cap_pin), .irq(irq)
  );

  // {is_write, address, data}; reads compare rd_data against data
  localparam logic [19:0] VEC [0:9] = '{
    {1'b1, 3'd3, 16'h0000},
    {1'b1, 3'd0, 16'h1234},
    {1'b0, 3'd0, 16'h1234},
    {1'b1, 3'd1, 16'hBEEF},
    {1'b0, 3'd1, 16'hBEEF},
    {1'b1, 3'd4, 16'h0007},
    {1'b0, 3'd4, 16'h0007},
    {1'b0, 3'd5, 16'h0000},
    {1'b0, 3'd2, 16'h0000},
    {1'b0, 3'd7, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_edges(input int m);
    repeat (m) @(posedge clk);
    #1;
  endtask

  task automatic rate(input logic [2:0] code, input int ratio, input int m, input string req);
    logic [15:0] v;
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0000);
    wr(3'd3, {13'd0, code});
    wait_edges(m);
    rd(3'd0, v);
    chk(req, v, 16'(m / ratio));
    wr(3'd3, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 16'h0000);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);

    // R2 vector table
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:0]);
      else begin
        rd(VEC[i][18:16], v);
        chk("R2 register map", v, VEC[i][15:0]);
      end
    end
    wr(3'd4, 16'h0000);

    // R3 stopped codes 0 and 6
    wr(3'd0, 16'h0005);
    wr(3'd3, 16'h0000);
    wait_edges(50);
    rd(3'd0, v); chk("R3 code 0 holds", v, 16'h0005);
    wr(3'd3, 16'h0006);
    wait_edges(50);
    rd(3'd0, v); chk("R3 code 6 holds", v, 16'h0005);

    // R4 divide ratios
    rate(3'd1, 1, 37, "R4 ratio 1");
    rate(3'd2, 8, 40, "R4 ratio 8");
    rate(3'd3, 64, 200, "R4 ratio 64");
    rate(3'd4, 256, 600, "R4 ratio 256");
    rate(3'd5, 1024, 2100, "R4 ratio 1024");

    // R5 overflow wrap
    wr(3'd0, 16'hFFFE);
    wr(3'd5, 16'h0007);
    wr(3'd4, 16'h0001);
    wr(3'd3, 16'h0001);
    wait_edges(1);
    rd(3'd5, v); chk("R5 no flag before wrap", v, 16'h0000);
    wait_edges(1);
    rd(3'd0, v); chk("R5 wrapped count", v, 16'h0000);
    rd(3'd5, v); chk("R5 overflow flag", v, 16'h0001);
    chk("R10 irq on enabled flag", {15'd0, irq}, 16'h0001);
    wr(3'd3, 16'h0000);

    // R10 flag set regardless of enable, irq masked
    wr(3'd4, 16'h0000);
    rd(3'd5, v); chk("R10 flag kept when disabled", v, 16'h0001);
    chk("R10 irq masked", {15'd0, irq}, 16'h0000);

    // R9 clear by writing 1
    wr(3'd5, 16'h0001);
    rd(3'd5, v); chk("R9 clear flag", v, 16'h0000);

    // R9 set wins over clear in same cycle
    wr(3'd0, 16'hFFFF);
    wr(3'd3, 16'h0001);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); chk("R9 set wins", v, 16'h0001);
    wr(3'd3, 16'h0000);
    wr(3'd5, 16'h0007);

    // R6 compare match
    wr(3'd0, 16'h0010);
    wr(3'd1, 16'h0012);
    wr(3'd4, 16'h0002);
    wr(3'd3, 16'h0001);
    wait_edges(2);
    rd(3'd5, v); chk("R6 no match yet", v, 16'h0000);
    wait_edges(1);
    rd(3'd5, v); chk("R6 compare flag", v, 16'h0002);
    chk("R6 irq on compare", {15'd0, irq}, 16'h0001);
    wr(3'd3, 16'h0000);
    wr(3'd5, 16'h0007);

    // R7 count write cancels match and loads immediately
    wr(3'd0, 16'h0050);
    wr(3'd1, 16'h0050);
    wr(3'd3, 16'h0001);
    wr(3'd0, 16'h0000);
    wait_edges(3);
    wr(3'd3, 16'h0000);
    rd(3'd5, v); chk("R7 match suppressed", v, 16'h0000);
    rd(3'd0, v); chk("R7 load then count", v, 16'h0004);
    wr(3'd4, 16'h0000);

    // R8 capture, rising edge selected
    wr(3'd3, 16'h0008);
    wr(3'd0, 16'h0ABC);
    @(negedge clk); cap_pin = 1'b1;
    wait_edges(4);
    rd(3'd2, v); chk("R8 rising capture value", v, 16'h0ABC);
    rd(3'd5, v); chk("R8 capture flag", v, 16'h0004);
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); chk("R2 capture read-only", v, 16'h0ABC);
    wr(3'd5, 16'h0007);
    wr(3'd0, 16'h0777);
    @(negedge clk); cap_pin = 1'b0;
    wait_edges(4);
    rd(3'd5, v); chk("R8 falling ignored in rising mode", v, 16'h0000);
    rd(3'd2, v); chk("R8 capture unchanged", v, 16'h0ABC);

    // R8 capture, falling edge selected
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0123);
    @(negedge clk); cap_pin = 1'b1;
    wait_edges(4);
    rd(3'd5, v); chk("R8 rising ignored in falling mode", v, 16'h0000);
    @(negedge clk); cap_pin = 1'b0;
    wait_edges(4);
    rd(3'd2, v); chk("R8 falling capture value", v, 16'h0123);
    rd(3'd5, v); chk("R8 falling capture flag", v, 16'h0004);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule